// File: doc/BRIEF.md
# SPI Register Target with Delayed Readback

This block is the serial front end of a small mixed-signal controller. A host drives a clock, a data line and an active-low frame strobe. The block collects 24-bit commands and applies writes to a compact register bank. A read request is answered in the following frame, and that answer echoes the request ahead of the data. The output shift path is the same one that passes commands down a chain of identical targets. All pin activity is oversampled in the system clock domain. The SPI clock therefore has to be slow relative to `clk`, and every action is keyed to synchronized pin edges.

The register bank holds one left-aligned code register per output channel. It also holds an interface configuration register with the output-enable and early-launch bits, and a lock bit. A trigger register accepts an unlock key and a soft-reset key. Address 0x00 does nothing. The channel codes leave the block on a packed output bus. The serial output is presented as a data bit plus an output enable, so that the pad ring can build the shared tri-state pin.

Top module: `spi_reg_target`

## Requirements
- R1: A frame is sent most significant bit first and sampled on the falling SCLK edge while the strobe is low. Bit 23 is the read flag (1 = read), bits 22..16 the address and bits 15..0 the data. A write to channel register 0x01+k updates that channel's code after the strobe rises.
- R2: A frame that ends with fewer than 24 falling clock edges is dropped. It writes nothing and leaves the word returned in the next frame unchanged.
- R3: After a read of address A, the next frame shifts out {1, A, contents of A} on SDO.
- R4: After a write frame, the next frame shifts out the 24 bits received. When a frame holds more than 24 edges, only the last 24 bits are decoded. SDO then carries the held response word followed by the received bits delayed by 24 clocks, which gives daisy chaining.
- R5: Register 0x10 bit 0 enables the serial output and bit 1 selects early launch; both reset to 0. The output enable is low whenever the strobe is high or bit 0 is clear, and SDO reads 0 while it is low.
- R6: In normal launch, SDO moves only after a rising SCLK edge. In early launch it moves after the falling edge, half a clock sooner. In both modes the first bit is valid from the falling strobe.
- R7: Writes to address 0x00 change nothing and reads of it return 0. Unmapped addresses also read 0.
- R8: A channel register keeps data bits 15..6 as a 10-bit code. Bits 5..0 are ignored on write and read back as 0.
- R9: Register 0x11 bit 0 is the lock. While it is set, writes to every address except 0x12 are ignored. Writing 0x12 with bits 3..0 = 0101 clears the lock.
- R10: Writing 0x12 with bits 15..12 = 1010 returns every register to its reset value. This works while locked and takes precedence over an unlock key in the same write.
- R11: After the reset pin is released, all channel codes are 0 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_sync_n | input | 1 | Active-low frame strobe |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out, 0 while not enabled |
| spi_sdo_oe | output | 1 | Output enable for the shared SDO pad |
| ch_code | output | NCH*CODE_W | Channel codes, channel k in bits k*CODE_W upward |

## Verification
The soft-reset key and the unlock key can arrive in the same trigger write, and both then act in one clock while the lock is set. The bench provokes this by locking the bank, loading channel codes and sending a single write that carries both keys. It judges the result at the ports. All channel codes must be zero, and SDO must stay disabled through the next frame. Once SDO is re-enabled, a read of the lock register must return 0 and a following channel write must land.

// File: rtl/spi_reg_pkg.sv
// Package spi_reg_pkg
// Shared frame layout, register addresses and key values for the SPI
// register target. Assumes a 1-bit read flag, 7-bit address, 16-bit data.
package spi_reg_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;

    localparam logic [ADDR_W-1:0] A_NOP       = 7'h00;
    localparam logic [ADDR_W-1:0] A_CODE_BASE = 7'h01;
    localparam logic [ADDR_W-1:0] A_IFCFG     = 7'h10;
    localparam logic [ADDR_W-1:0] A_LOCK      = 7'h11;
    localparam logic [ADDR_W-1:0] A_TRIG      = 7'h12;

    localparam logic [3:0] UNLOCK_KEY = 4'b0101;
    localparam logic [3:0] SRST_KEY   = 4'b1010;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Module spi_pin_sync
// Brings W asynchronous pins into the clk domain through a STAGES-deep
// flop chain. It reports the settled level and one-cycle rise/fall pulses.
// Assumes each pin holds a level for several clk cycles.
module spi_pin_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev;

    // first stage samples the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= pin_i;
    end

    genvar gs;
    generate
        for (gs = 1; gs < STAGES; gs++) begin : g_stage
            // each further stage retimes the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gs] <= RST_VAL;
                else        chain[gs] <= chain[gs-1];
            end
        end
    endgenerate

    // previous settled level kept for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];
    end

    assign lvl_o  = chain[STAGES-1];
    assign rise_o = lvl_o & ~prev;
    assign fall_o = ~lvl_o & prev;
endmodule

// File: rtl/spi_frame_shifter.sv
// Module spi_frame_shifter
// A single shift register takes SDI at its bottom and presents SDO at its top.
// At frame start it loads the held response word. At frame end it reports a
// commit when at least FRAME_W bits arrived, and then forms the next response
// as a read answer or as an echo. Assumes event pulses come from spi_pin_sync.
module spi_frame_shifter
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              shift_evt,
    input  logic              launch_evt,
    input  logic              sdi_bit,
    input  logic              fast_mode,
    input  logic [DATA_W-1:0] rdata,
    output frame_t            rx_word,
    output logic              commit,
    output logic              sdo_bit
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    frame_t           sr;
    frame_t           resp;
    frame_t           next_resp;
    logic [CNT_W-1:0] cnt;
    logic             hold;

    assign commit  = frame_end && (cnt == CNT_FULL);
    assign rx_word = sr;

    // shift register and saturating bit counter for the running frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (frame_start) begin
            sr  <= resp;
            cnt <= '0;
        end else if (shift_evt) begin
            sr  <= frame_t'({sr[FRAME_W-2:0], sdi_bit});
            if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
        end
    end

    // response for the next frame: read answer or echo of the command
    always_comb begin
        next_resp = sr;
        if (sr.rd) begin
            next_resp.rd   = 1'b1;
            next_resp.addr = sr.addr;
            next_resp.data = rdata;
        end
    end

    // hold the response word; dropped frames leave it untouched
    always_ff @(posedge clk) begin
        if (!rst_n)      resp <= '0;
        else if (commit) resp <= next_resp;
    end

    // normal-launch output flop, updated on rising SCLK
    always_ff @(posedge clk) begin
        if (!rst_n)          hold <= 1'b0;
        else if (frame_start) hold <= resp.rd;
        else if (launch_evt) hold <= sr[FRAME_W-1];
    end

    assign sdo_bit = fast_mode ? sr[FRAME_W-1] : hold;
endmodule

// File: rtl/spi_reg_bank.sv
// Module spi_reg_bank
// Register bank behind the SPI target. It holds NCH left-aligned channel
// codes, the output configuration, a lock bit, and a trigger register with
// unlock and soft-reset keys. Assumes wr_stb is a one-cycle pulse.
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CODE_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rdata,
    output logic [NCH*CODE_W-1:0] ch_code,
    output logic                  sdo_en,
    output logic                  fast_mode,
    output logic                  locked
);
    localparam int PAD_W = DATA_W - CODE_W;

    logic [CODE_W-1:0] code [NCH];
    logic              soft_rst;
    logic              unlock_hit;
    logic              wr_open;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign soft_rst   = wr_stb && (wr_addr == A_TRIG) && (wr_data[15:12] == SRST_KEY);
    assign unlock_hit = wr_stb && (wr_addr == A_TRIG) && (wr_data[3:0] == UNLOCK_KEY);
    assign wr_open    = wr_stb && !locked;

    // configuration and lock bits with key handling
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sdo_en    <= 1'b0;
            fast_mode <= 1'b0;
            locked    <= 1'b0;
        end else begin
            if (wr_open && wr_addr == A_IFCFG) begin
                sdo_en    <= wr_data[0];
                fast_mode <= wr_data[1];
            end
            if (unlock_hit)
                locked <= 1'b0;
            else if (wr_open && wr_addr == A_LOCK)
                locked <= wr_data[0];
        end
    end

    genvar gc;
    generate
        for (gc = 0; gc < NCH; gc++) begin : g_chan
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_CODE_BASE) + gc);
            // channel code register keeps the upper CODE_W data bits
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    code[gc] <= '0;
                else if (wr_open && wr_addr == MY_ADDR)
                    code[gc] <= wr_data[DATA_W-1 -: CODE_W];
            end
            assign ch_code[gc*CODE_W +: CODE_W] = code[gc];
        end
    endgenerate

    // read multiplexer; unmapped and write-only addresses return zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(int'(A_CODE_BASE) + i))
                rdata = DATA_W'(code[i]) << PAD_W;
        end
        if (rd_addr == A_IFCFG) rdata = DATA_W'({fast_mode, sdo_en});
        if (rd_addr == A_LOCK)  rdata = DATA_W'(locked);
    end
endmodule

// File: rtl/spi_reg_target.sv
// Module spi_reg_target
// Top of the SPI register target. It synchronizes the pins, turns pin edges
// into frame events, runs the frame shifter and the register bank, and gates
// SDO with its output enable. Assumes SCLK idles high and each SCLK phase
// lasts at least SYNC_STAGES+2 clk cycles.
module spi_reg_target
    import spi_reg_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int CODE_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_sync_n,
    input  logic                  spi_sdi,
    output logic                  spi_sdo,
    output logic                  spi_sdo_oe,
    output logic [NCH*CODE_W-1:0] ch_code
);
    localparam int PIN_N = 3;
    localparam int P_SYNC = 2;
    localparam int P_SCLK = 1;
    localparam int P_SDI  = 0;

    logic [PIN_N-1:0]  pin_lvl, pin_rise, pin_fall;
    logic              frame_active, frame_start, frame_end;
    logic              shift_evt, launch_evt;
    logic              commit, sdo_bit;
    logic              sdo_en, fast_mode, locked;
    logic [DATA_W-1:0] rdata;
    frame_t            rx_word;
    logic              unused_edges;

    spi_pin_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({spi_sync_n, spi_sclk, spi_sdi}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign unused_edges = ^{pin_rise[P_SDI], pin_fall[P_SDI]};
    assign frame_active = !pin_lvl[P_SYNC];
    assign frame_start  = pin_fall[P_SYNC];
    assign frame_end    = pin_rise[P_SYNC];
    assign shift_evt    = frame_active && pin_fall[P_SCLK];
    assign launch_evt   = frame_active && pin_rise[P_SCLK];

    spi_frame_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .shift_evt   (shift_evt),
        .launch_evt  (launch_evt),
        .sdi_bit     (pin_lvl[P_SDI]),
        .fast_mode   (fast_mode),
        .rdata       (rdata),
        .rx_word     (rx_word),
        .commit      (commit),
        .sdo_bit     (sdo_bit)
    );

    spi_reg_bank #(
        .NCH    (NCH),
        .CODE_W (CODE_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (commit && !rx_word.rd),
        .wr_addr   (rx_word.addr),
        .wr_data   (rx_word.data),
        .rd_addr   (rx_word.addr),
        .rdata     (rdata),
        .ch_code   (ch_code),
        .sdo_en    (sdo_en),
        .fast_mode (fast_mode),
        .locked    (locked)
    );

    assign spi_sdo_oe = sdo_en && frame_active;
    assign spi_sdo    = spi_sdo_oe && sdo_bit;
endmodule

// File: rtl/spi_reg_target_chk.sv
// Module spi_reg_target_chk
// Property checker bound into spi_reg_target. It watches output gating,
// the register-update timing, lock blocking, soft reset and normal launch.
module spi_reg_target_chk
    import spi_reg_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CODE_W = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_active,
    input logic                  frame_start,
    input logic                  launch_evt,
    input logic                  commit,
    input logic [FRAME_W-1:0]    rx_word,
    input logic                  locked,
    input logic                  fast_mode,
    input logic                  spi_sdo,
    input logic                  spi_sdo_oe,
    input logic [NCH*CODE_W-1:0] ch_code
);
    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdo_oe |-> frame_active); // R5

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sdo_oe |-> !spi_sdo); // R5

    AST_CODE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_code) |-> $past(commit)); // R2

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rx_word[FRAME_W-1] && locked && rx_word[FRAME_W-2 -: ADDR_W] != A_TRIG)
        |=> $stable(ch_code)); // R9

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rx_word[FRAME_W-1] && rx_word[FRAME_W-2 -: ADDR_W] == A_TRIG
         && rx_word[15:12] == SRST_KEY)
        |=> (ch_code == '0) && !locked); // R10

    AST_NORMAL_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && $past(frame_active) && !fast_mode
         && !$past(launch_evt) && !$past(frame_start))
        |-> $stable(spi_sdo)); // R6
endmodule

bind spi_reg_target spi_reg_target_chk #(
    .NCH    (NCH),
    .CODE_W (CODE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .frame_start  (frame_start),
    .launch_evt   (launch_evt),
    .commit       (commit),
    .rx_word      (rx_word),
    .locked       (locked),
    .fast_mode    (fast_mode),
    .spi_sdo      (spi_sdo),
    .spi_sdo_oe   (spi_sdo_oe),
    .ch_code      (ch_code)
);

// File: tb/spi_reg_target_bench.sv
`timescale 1ns/1ps
// Directed bench for spi_reg_target: one task per scenario.
module spi_reg_target_bench;
    localparam int NCH    = 3;
    localparam int CODE_W = 10;
    localparam int HALF   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sync_n = 1'b1, sdi = 1'b0;
    logic sdo, oe;
    logic [NCH*CODE_W-1:0] ch_code;

    int checks = 0;
    int errors = 0;
    logic [CODE_W-1:0] shadow [NCH];

    logic [47:0] rx, mid;
    logic        oe_seen;
    logic [15:0] rdv;

    always #4 clk = ~clk;

    spi_reg_target #(.NCH(NCH), .CODE_W(CODE_W)) u_spi_reg_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (sclk),
        .spi_sync_n (sync_n),
        .spi_sdi    (sdi),
        .spi_sdo    (sdo),
        .spi_sdo_oe (oe),
        .ch_code    (ch_code)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one frame of nbits, MSB first; samples SDO before each fall and mid-low
    task automatic xfer(input logic [47:0] pay, input int nbits);
        rx = '0; mid = '0; oe_seen = 1'b0;
        sync_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = pay[nbits-1-i];
            wait_clks(HALF);
            rx[nbits-1-i] = sdo;
            oe_seen |= oe;
            sclk = 1'b0;
            wait_clks(6);
            mid[nbits-1-i] = sdo;
            wait_clks(HALF-6);
            sclk = 1'b1;
        end
        wait_clks(HALF);
        sync_n = 1'b1;
        wait_clks(3*HALF);
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        xfer(48'({1'b0, a, d}), 24);
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        xfer(48'({1'b1, a, 16'h0000}), 24);
        xfer(48'h0, 24);
        d = rx[15:0];
    endtask

    task automatic check_codes(input string tag);
        for (int k = 0; k < NCH; k++)
            check(tag, 48'(ch_code[k*CODE_W +: CODE_W]), 48'(shadow[k]));
    endtask

    task automatic t_reset;
        check("R11 oe after reset", 48'(oe), 48'h0);
        check("R11 codes after reset", 48'(ch_code), 48'h0);
        for (int k = 0; k < NCH; k++) shadow[k] = '0;
        wr(7'h01, 16'h8040);
        shadow[0] = 10'h201;
        check("R5 oe low while disabled", 48'(oe_seen), 48'h0);
        check_codes("R1 channel write");
    endtask

    task automatic t_enable_read;
        wr(7'h10, 16'h0001);
        xfer(48'({1'b1, 7'h10, 16'h0}), 24);
        check("R5 oe seen when enabled", 48'(oe_seen), 48'h1);
        xfer(48'h0, 24);
        check("R3 read answer frame", rx, 48'({1'b1, 7'h10, 16'h0001}));
        check("R6 normal launch holds through low phase", mid, rx);
        check("R5 oe low with strobe high", 48'(oe), 48'h0);
    endtask

    task automatic t_codes;
        for (int k = 0; k < NCH; k++) begin
            logic [15:0] d;
            d = 16'hABCD ^ 16'(k * 16'h1357);
            wr(7'(1 + k), d);
            shadow[k] = d[15:6];
            rd(7'(1 + k), rdv);
            check("R8 left-aligned readback", 48'(rdv), 48'({d[15:6], 6'b0}));
        end
        check_codes("R8 code bits 15..6");
    endtask

    task automatic t_echo;
        wr(7'h03, 16'h1234);
        shadow[2] = 10'h048;
        xfer(48'h0, 24);
        check("R4 write echo", rx, 48'({1'b0, 7'h03, 16'h1234}));
    endtask

    task automatic t_nop;
        wr(7'h00, 16'h1234);
        check_codes("R7 nop write has no effect");
        rd(7'h00, rdv);
        check("R7 nop reads zero", 48'(rdv), 48'h0);
        rd(7'h55, rdv);
        check("R7 unmapped reads zero", 48'(rdv), 48'h0);
    endtask

    task automatic t_short;
        logic [23:0] w0, w1;
        w0 = {1'b0, 7'h02, 16'h4440};
        w1 = {1'b0, 7'h02, 16'hFFFF};
        wr(w0[22:16], w0[15:0]);
        shadow[1] = 10'h111;
        xfer(48'(w1 >> 4), 20);
        check_codes("R2 short frame writes nothing");
        xfer(48'h0, 24);
        check("R2 short frame keeps response", rx, 48'(w0));
    endtask

    task automatic t_daisy;
        logic [23:0] wa, wb;
        wa = {1'b0, 7'h01, 16'h3FC0};
        wb = {1'b0, 7'h03, 16'h0100};
        xfer({wa, wb}, 48);
        shadow[2] = 10'h004;
        check("R4 chain first half is held word", 48'(rx[47:24]), 48'h0);
        check("R4 chain second half is delayed input", 48'(rx[23:0]), 48'(wa));
        check_codes("R4 only last 24 bits decoded");
        xfer(48'h0, 24);
        check("R4 chain echo of last word", rx, 48'(wb));
    endtask

    task automatic t_fast;
        wr(7'h10, 16'h0003);
        xfer(48'({1'b1, 7'h10, 16'h0}), 24);
        check("R6 fast frame data", rx, 48'({1'b0, 7'h10, 16'h0003}));
        check("R6 fast launch half cycle early", 48'(mid[23:1]), 48'(rx[22:0]));
        xfer(48'h0, 24);
        check("R3 read in fast mode", rx, 48'({1'b1, 7'h10, 16'h0003}));
        wr(7'h10, 16'h0001);
    endtask

    task automatic t_lock;
        wr(7'h11, 16'h0001);
        rd(7'h11, rdv);
        check("R9 lock reads set", 48'(rdv), 48'h1);
        wr(7'h01, 16'hFFC0);
        check_codes("R9 locked channel write ignored");
        wr(7'h10, 16'h0000);
        rd(7'h10, rdv);
        check("R9 locked config write ignored", 48'(rdv), 48'h1);
        wr(7'h12, 16'h0005);
        wr(7'h01, 16'hFFC0);
        shadow[0] = 10'h3FF;
        check_codes("R9 unlock key reopens writes");
    endtask

    task automatic t_srst;
        wr(7'h11, 16'h0001);
        wr(7'h12, 16'hA005);
        for (int k = 0; k < NCH; k++) shadow[k] = '0;
        check_codes("R10 soft reset clears codes while locked");
        xfer(48'h0, 24);
        check("R10 soft reset disables sdo", 48'(oe_seen), 48'h0);
        wr(7'h10, 16'h0001);
        rd(7'h11, rdv);
        check("R10 lock cleared by soft reset", 48'(rdv), 48'h0);
        wr(7'h02, 16'h8000);
        shadow[1] = 10'h200;
        check_codes("R10 writes open after soft reset");
    endtask

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        t_reset();
        t_enable_read();
        t_codes();
        t_echo();
        t_nop();
        t_short();
        t_daisy();
        t_fast();
        t_lock();
        t_srst();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule